// File: doc/BRIEF.md
# Sine/Cosine Synthesizer with Recoded-Phase Rotation

The block produces a continuous pair of sine and cosine samples whose frequency is set by a 24-bit tuning word. Every clock, a phase register adds the tuning word and wraps around modulo 2^24. Its 16 most significant bits are kept. The top two of these pick a quadrant. The next six address a small table of pre-scaled (cos, sin) pairs, and that table lookup is the coarse rotation. The lowest eight bits are read as bipolar digits, each worth plus or minus one, so every bit directly gives the sign of a fixed fine rotation. No residual angle is ever computed.

The fine rotation is split into two merged steps. Each step takes four digits at once and folds them into a single multi-operand sum built as a three-level adder tree. The final stage rounds the result, maps the first-quadrant values into the right quadrant by swapping and negating them, and registers the outputs. The table constants carry the gain compensation, so no multiplier is needed. A valid flag travels with the data.

Top module: `tsc_ddfs`

## Requirements
- R1: The phase register is 24 bits wide, starts at 0 after reset and adds `fcw_i` on every clock modulo 2^24. A tuning word of 0 holds the phase, and 24'hFFFFFF steps it back by one count, wrapping below zero.
- R2: From the 4th rising edge after reset release, `valid_o` is 1 and stays 1. The sample shown after edge t reflects the phase value that the register held after edge t-4, where edge 0 is the release.
- R3: While `valid_o` is 0, `sin_o` and `cos_o` are both 0. `valid_o` is 0 after each of the first three edges following reset release.
- R4: Let P be bits 23..8 of the phase. P[15:14] selects the quadrant (0 to 3). With s and c the first-quadrant results, the outputs (sin, cos) are (s, c) for quadrant 0, (c, -s) for quadrant 1, (-s, -c) for quadrant 2 and (-c, s) for quadrant 3.
- R5: `sin_o` is within 6 LSB of round(32760 * sin(2*pi*(P+0.5)/65536)), as a 16-bit two's-complement value.
- R6: `cos_o` is within 6 LSB of round(32760 * cos(2*pi*(P+0.5)/65536)), as a 16-bit two's-complement value.
- R7: Driving `rst_ni` low clears the phase, the pipeline and the outputs at once. After release the sequence restarts from phase 0 with the timing of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcw_i | input | 24 | Frequency tuning word added to the phase every clock |
| valid_o | output | 1 | Output sample is valid |
| sin_o | output | 16 | Sine sample, two's complement |
| cos_o | output | 16 | Cosine sample, two's complement |

## Verification
Several tuning words are run, each from a fresh reset, and every sample is compared with a real-valued sine and cosine of the delayed phase. A small odd word sweeps fine digit patterns inside one quadrant. A quarter-turn word lands exactly on each quadrant start, which separates the four swap and sign cases. The all-ones word walks the phase backwards across the wrap and tests the modulo behaviour. The zero word holds a single phase and shows that nothing drifts. A word just under a quarter turn lands next to the boundaries and makes the coarse index roll over while the digit patterns are extreme. A mid-run reset then shows that the outputs clear at once and that the sequence restarts at phase 0 with the same latency.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef logic [1:0] quad_t;
  localparam real PI = 3.14159265358979323846;
endpackage

// File: rtl/tsc_phase_acc.sv
module tsc_phase_acc #(
  parameter int PHASE_W = 24,
  parameter int TRUNC_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] fcw_i,
  output logic [TRUNC_W-1:0] phase_o
);
  logic [PHASE_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + fcw_i;
  end

  assign phase_o = acc_q[PHASE_W-1 -: TRUNC_W];
endmodule

// File: rtl/tsc_coarse_lut.sv
module tsc_coarse_lut
  import tsc_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int RES_W = 8,
  parameter int IW    = 24,
  parameter int AMP   = 32760,
  parameter int GUARD = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDX_W-1:0]     idx_i,
  output logic signed [IW-1:0] cos_o,
  output logic signed [IW-1:0] sin_o,
  output logic signed [IW-1:0] ucos_o,
  output logic signed [IW-1:0] usin_o
);
  localparam int  N   = 2**IDX_W;
  // fine-step scale: angle of digit weight 2^(RES_W-1)
  localparam real US  = PI / (2.0**(IDX_W + 2));
  // cancels mean gain of the small-angle fine rotations
  localparam real KG  = 1.0 - US * US / 6.0;
  localparam real SC  = real'(AMP) * KG * (2.0**GUARD);

  logic signed [IW-1:0] rom_c [N];
  logic signed [IW-1:0] rom_s [N];
  logic signed [IW-1:0] rom_uc[N];
  logic signed [IW-1:0] rom_us[N];

  for (genvar i = 0; i < N; i++) begin : g_rom
    localparam real TH = (real'(i) * (2.0**RES_W) + 2.0**(RES_W-1)) * (PI / 2.0)
                         / (2.0**(IDX_W + RES_W));
    localparam int CI  = int'(SC * $cos(TH));
    localparam int SI  = int'(SC * $sin(TH));
    localparam int UCI = int'(SC * US * $cos(TH));
    localparam int USI = int'(SC * US * $sin(TH));
    assign rom_c[i]  = CI[IW-1:0];
    assign rom_s[i]  = SI[IW-1:0];
    assign rom_uc[i] = UCI[IW-1:0];
    assign rom_us[i] = USI[IW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_o <= '0; sin_o <= '0; ucos_o <= '0; usin_o <= '0;
    end else begin
      cos_o  <= rom_c[idx_i];
      sin_o  <= rom_s[idx_i];
      ucos_o <= rom_uc[idx_i];
      usin_o <= rom_us[idx_i];
    end
  end
endmodule

// File: rtl/tsc_merge_step.sv
module tsc_merge_step #(
  parameter int IW    = 24,
  parameter int NT    = 4,
  parameter int RES_W = 8,
  parameter int J0    = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [IW-1:0] uc_i,
  input  logic signed [IW-1:0] us_i,
  input  logic [NT-1:0]        dig_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o
);
  localparam int NOP = NT + 1;
  localparam int LV  = $clog2(NOP);
  localparam int NP  = 2**LV;

  logic signed [IW-1:0] lx [LV+1][NP];
  logic signed [IW-1:0] ly [LV+1][NP];

  always_comb begin
    for (int l = 0; l <= LV; l++)
      for (int i = 0; i < NP; i++) begin
        lx[l][i] = '0;
        ly[l][i] = '0;
      end
    lx[0][0] = x_i;
    ly[0][0] = y_i;
    for (int k = 0; k < NT; k++) begin
      logic signed [IW-1:0] tx, ty;
      tx = us_i >>> (RES_W - J0 - k);
      ty = uc_i >>> (RES_W - J0 - k);
      // bit 1 -> digit +1 (rotate forward), bit 0 -> digit -1
      lx[0][k+1] = dig_i[k] ? -tx : tx;
      ly[0][k+1] = dig_i[k] ? ty : -ty;
    end
    for (int l = 0; l < LV; l++)
      for (int i = 0; i < NP/2; i++) begin
        lx[l+1][i] = lx[l][2*i] + lx[l][2*i+1];
        ly[l+1][i] = ly[l][2*i] + ly[l][2*i+1];
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0; y_o <= '0;
    end else begin
      x_o <= lx[LV][0];
      y_o <= ly[LV][0];
    end
  end
endmodule

// File: rtl/tsc_quad_fold.sv
module tsc_quad_fold
  import tsc_pkg::*;
#(
  parameter int IW    = 24,
  parameter int GUARD = 6,
  parameter int OUT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    v_i,
  input  quad_t                   q_i,
  input  logic signed [IW-1:0]    x_i,
  input  logic signed [IW-1:0]    y_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);
  localparam int MAXO = 2**(OUT_W-1) - 1;
  localparam int HALF = 2**(GUARD-1);

  function automatic logic signed [OUT_W-1:0] rnd(input logic signed [IW-1:0] v);
    logic signed [IW-1:0] t;
    t = (v + IW'(HALF)) >>> GUARD;
    if (t > IW'(MAXO))       t = IW'(MAXO);
    else if (t < IW'(-MAXO)) t = IW'(-MAXO);
    return t[OUT_W-1:0];
  endfunction

  logic signed [OUT_W-1:0] c_r, s_r, sin_d, cos_d;

  always_comb begin
    c_r = rnd(x_i);
    s_r = rnd(y_i);
    unique case (q_i)
      2'd0:    begin sin_d = s_r;  cos_d = c_r;  end
      2'd1:    begin sin_d = c_r;  cos_d = -s_r; end
      2'd2:    begin sin_d = -s_r; cos_d = -c_r; end
      default: begin sin_d = -c_r; cos_d = s_r;  end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; sin_o <= '0; cos_o <= '0;
    end else if (v_i) begin
      valid_o <= 1'b1; sin_o <= sin_d; cos_o <= cos_d;
    end else begin
      valid_o <= 1'b0; sin_o <= '0; cos_o <= '0;
    end
  end

  // R3
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (sin_o == '0 && cos_o == '0));
  // R2
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  // R4
  quad0_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && q_i == 2'd0) |=> (!sin_o[OUT_W-1] && !cos_o[OUT_W-1]));
  // R4
  quad2_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && q_i == 2'd2) |=> (sin_o <= 0 && cos_o <= 0));
endmodule

// File: rtl/tsc_ddfs.sv
module tsc_ddfs
  import tsc_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int TRUNC_W = 16,
  parameter int LUT_W   = 6,
  parameter int OUT_W   = 16,
  parameter int GUARD   = 6,
  parameter int AMP     = 32760
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PHASE_W-1:0]      fcw_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);
  localparam int ANG_W = TRUNC_W - 2;
  localparam int RES_W = ANG_W - LUT_W;
  localparam int LO_N  = RES_W / 2;
  localparam int HI_N  = RES_W - LO_N;
  localparam int IW    = OUT_W + GUARD + 2;
  localparam int CORE_LIM = (2**(OUT_W-1)) * (2**GUARD);

  logic [TRUNC_W-1:0] phase;

  tsc_phase_acc #(.PHASE_W(PHASE_W), .TRUNC_W(TRUNC_W)) i_acc (
    .clk_i, .rst_ni, .fcw_i, .phase_o(phase)
  );

  // step 1: coarse rotation by table lookup
  logic signed [IW-1:0] c1, s1, uc1, us1;
  quad_t                s1_q;
  logic [RES_W-1:0]     s1_dig;
  logic                 s1_v;

  tsc_coarse_lut #(.IDX_W(LUT_W), .RES_W(RES_W), .IW(IW), .AMP(AMP), .GUARD(GUARD)) i_lut (
    .clk_i, .rst_ni, .idx_i(phase[ANG_W-1 -: LUT_W]),
    .cos_o(c1), .sin_o(s1), .ucos_o(uc1), .usin_o(us1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0; s1_dig <= '0; s1_v <= 1'b0;
    end else begin
      s1_q   <= phase[TRUNC_W-1 -: 2];
      s1_dig <= phase[RES_W-1:0];
      s1_v   <= 1'b1;
    end
  end

  // step 2: merged rotation, upper digits
  logic signed [IW-1:0] x2, y2, uc2, us2;
  quad_t                s2_q;
  logic [LO_N-1:0]      s2_dig;
  logic                 s2_v;

  tsc_merge_step #(.IW(IW), .NT(HI_N), .RES_W(RES_W), .J0(LO_N)) i_step_hi (
    .clk_i, .rst_ni, .x_i(c1), .y_i(s1), .uc_i(uc1), .us_i(us1),
    .dig_i(s1_dig[RES_W-1:LO_N]), .x_o(x2), .y_o(y2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uc2 <= '0; us2 <= '0; s2_q <= '0; s2_dig <= '0; s2_v <= 1'b0;
    end else begin
      uc2 <= uc1; us2 <= us1; s2_q <= s1_q;
      s2_dig <= s1_dig[LO_N-1:0]; s2_v <= s1_v;
    end
  end

  // step 3: merged rotation, lower digits
  logic signed [IW-1:0] x3, y3;
  quad_t                s3_q;
  logic                 s3_v;

  tsc_merge_step #(.IW(IW), .NT(LO_N), .RES_W(RES_W), .J0(0)) i_step_lo (
    .clk_i, .rst_ni, .x_i(x2), .y_i(y2), .uc_i(uc2), .us_i(us2),
    .dig_i(s2_dig), .x_o(x3), .y_o(y3)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s3_q <= '0; s3_v <= 1'b0;
    end else begin
      s3_q <= s2_q; s3_v <= s2_v;
    end
  end

  // R5
  core_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s3_v |-> (x3 >= 0 && y3 >= 0 && x3 < CORE_LIM && y3 < CORE_LIM));

  tsc_quad_fold #(.IW(IW), .GUARD(GUARD), .OUT_W(OUT_W)) i_fold (
    .clk_i, .rst_ni, .v_i(s3_v), .q_i(s3_q), .x_i(x3), .y_i(y3),
    .valid_o, .sin_o, .cos_o
  );
endmodule

// File: tb/test_tsc_ddfs.sv
module test_tsc_ddfs;
  localparam real PI  = 3.14159265358979323846;
  localparam int  AMP = 32760;
  localparam int  TOL = 6;
  localparam int  NV  = 6;
  localparam logic [23:0] FCW_TAB [NV] = '{
    24'h012345, 24'h400000, 24'hFFFFFF, 24'h000000, 24'h3FFF00, 24'hABCDEF };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] fcw = '0;
  logic        valid;
  logic signed [15:0] sin_v, cos_v;

  int tests = 0, fails = 0, t = 0;
  logic [23:0] macc;
  logic [23:0] hist [5];
  bit done = 0;

  always #5 clk = ~clk;

  tsc_ddfs i_tsc_ddfs (.clk_i(clk), .rst_ni(rst_n), .fcw_i(fcw),
                       .valid_o(valid), .sin_o(sin_v), .cos_o(cos_v));

  function automatic int exp_val(input logic [23:0] a, input bit is_cos);
    real th;
    th = 2.0 * PI * (real'(a[23:8]) + 0.5) / 65536.0;
    return int'(real'(AMP) * (is_cos ? $cos(th) : $sin(th)));
  endfunction

  task automatic chk_eq(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (t=%0d)", tag, act, exp, t);
    end
  endtask

  task automatic chk_near(input string tag, input int act, input int exp);
    int d;
    tests++;
    d = act - exp;
    if (d > TOL || d < -TOL) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (t=%0d)", tag, act, exp, t);
    end
  endtask

  task automatic model_reset();
    t = 0; macc = '0;
    for (int k = 0; k < 5; k++) hist[k] = '0;
  endtask

  // one clock: update model at the edge, check at the falling edge
  task automatic step(input string tag);
    @(posedge clk);
    for (int k = 4; k > 0; k--) hist[k] = hist[k-1];
    macc = macc + fcw;
    hist[0] = macc;
    @(negedge clk);
    t++;
    if (t < 4) begin
      chk_eq("R3 valid", int'(valid), 0);
      chk_eq("R3 sin", int'(sin_v), 0);
      chk_eq("R3 cos", int'(cos_v), 0);
    end else begin
      chk_eq("R2 valid", int'(valid), 1);
      chk_near({tag, " R5 sin"}, int'(sin_v), exp_val(hist[4], 1'b0));
      chk_near({tag, " R6 cos"}, int'(cos_v), exp_val(hist[4], 1'b1));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_eq("R7 valid", int'(valid), 0);
    chk_eq("R7 sin", int'(sin_v), 0);
    chk_eq("R7 cos", int'(cos_v), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  function automatic string tag_of(input int i);
    case (i)
      1: return "R4";
      2: return "R1";
      3: return "R1";
      4: return "R4";
      default: return "R2";
    endcase
  endfunction

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk_eq("R3 reset valid", int'(valid), 0);
    chk_eq("R3 reset sin", int'(sin_v), 0);
    // vector table
    for (int v = 0; v < NV; v++) begin
      fcw = FCW_TAB[v];
      do_reset();
      for (int c = 0; c < 40; c++) step(tag_of(v));
    end
    // R1: change word mid-run, phase keeps accumulating
    fcw = 24'h000100;
    do_reset();
    for (int c = 0; c < 10; c++) step("R1");
    fcw = 24'h7FF000;
    for (int c = 0; c < 20; c++) step("R1");
    // R7: reset mid-run restarts from phase 0
    do_reset();
    for (int c = 0; c < 4; c++) step("R7");
    chk_near("R7 restart cos", int'(cos_v), AMP);
    chk_near("R7 restart sin", int'(sin_v), exp_val(24'h0, 1'b0));
    for (int c = 0; c < 10; c++) step("R7");
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule